// File: doc/BRIEF.md
# Low-Power Pseudo-Static RAM Behavioural Model

This block is a clock-sampled, synthesizable model of a 16-bit-wide pseudo-static RAM. Its pins follow the usual asynchronous SRAM style: a word address, an active-low chip select, an active-low sleep pin, output and write strobes, and two active-low byte-lane enables. The bidirectional data bus is split into an input word, an output word and one output-enable bit per byte lane. On each rising clock edge the model samples the pins and decodes them into one of six cycle kinds: standby, sleep, mode-register load, write, read, or an enabled cycle that does nothing.

A small mode register, loaded from the low address bits, sets what a sleep does. Sleep can be a deep power-down that loses the whole array, or a partial retention that keeps a region starting at word 0 and loses everything above it. The array keeps a validity flag for each byte lane of each word. A lane that was never written, or that a sleep has lost, reads back as a fixed poison byte until it is written again. The array depth is a parameter, so a test run can use a small array. A two-bit power-state output shows which state the part is in.

Top module: `psram_model`

## Requirements
- R1: While reset is held and after its release, pwr_state is STANDBY (01) and dq_oe is 00. The mode register resets to sleep type retention (bit 4 = 1) with partition code 00. Every lane of every word is invalid, so a read returns the poison word 16'hDEAD: high lane 8'hDE, low lane 8'hAD.
- R2: A cycle with ce_n=1 and zz_n=1 is a deselect. One cycle later pwr_state is STANDBY (01) and dq_oe is 00, and the array is not touched.
- R3: A cycle with ce_n=0, zz_n=1 and we_n=0 is a write, whatever oe_n is. The low lane (dq_in[7:0]) is stored when lb_n=0 and the high lane (dq_in[15:8]) when ub_n=0. A written lane becomes valid. A lane whose enable is high keeps its old contents and its old validity.
- R4: A cycle with ce_n=0, zz_n=1, we_n=1 and oe_n=0 is a read. One cycle later dq_oe[0] equals !lb_n and dq_oe[1] equals !ub_n. Each enabled lane of dq_out carries the stored byte, or the poison byte if that lane is invalid. Each disabled lane carries 8'h00.
- R5: A cycle with ce_n=0, zz_n=1, we_n=1 and oe_n=1 performs no access. One cycle later dq_oe is 00 and pwr_state is ACTIVE (00). Any cycle with ce_n=0 gives ACTIVE one cycle later.
- R6: A cycle with ce_n=0, zz_n=0 and we_n=0 loads addr[4] and addr[1:0] into the mode register and does not touch the array. With ce_n=0, zz_n=0 and we_n=1, neither the register nor the array changes.
- R7: A cycle with ce_n=1 and zz_n=0, taken from a non-sleep state, enters sleep. One cycle later pwr_state is DPD (10) if mode bit 4 is 0, or RETAIN (11) if it is 1. Further sleep cycles hold that state, and the mode bit is sampled only on entry.
- R8: Entering DPD makes every lane of every word invalid.
- R9: Entering RETAIN keeps the words below a limit and invalidates every word at or above it. Partition code 00 keeps the whole array, 01 keeps three quarters, 10 keeps one half and 11 keeps one quarter.
- R10: The word is selected by the full address, and reads can run back to back. Sweeping addr[1:0] over a 4-word page on consecutive read cycles returns one word per clock, each word one cycle after its address.
- R11: Each byte lane has its own validity. Writing only one lane after a loss leaves the other lane reading poison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address; bits 4 and 1:0 are the mode value during a register load |
| ce_n | input | 1 | Chip enable, active low |
| zz_n | input | 1 | Sleep / register-access pin, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Low byte-lane enable, active low |
| ub_n | input | 1 | High byte-lane enable, active low |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data, registered |
| dq_oe | output | 2 | Per-lane drive enable: bit 0 low lane, bit 1 high lane |
| pwr_state | output | 2 | 00 ACTIVE, 01 STANDBY, 10 DPD, 11 RETAIN |

## Verification
Every result appears exactly one clock after the cycle that caused it: read data and lane enables, the power state, and the data loss seen on the first read after a wake. The bench drives pins on the falling edge. Its behavioural model then works out the expected outputs for that cycle, and it compares dq_out, dq_oe and pwr_state 2 ns after the next rising edge, so each comparison falls in the one cycle where the value is due. The model is updated once per clock, which keeps register loads, sleep entry and losses aligned with the design's single register stage.

// File: rtl/psram_pkg.sv
package psram_pkg;

  localparam int unsigned LANE_W  = 8;
  localparam int unsigned LANES   = 2;
  localparam int unsigned DATA_W  = LANE_W * LANES;
  localparam logic [DATA_W-1:0] POISON = 16'hDEAD;

  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_SLEEP = 3'd1,
    CMD_CFG   = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_READ  = 3'd4,
    CMD_NOP   = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_ACTIVE  = 2'b00,
    PWR_STANDBY = 2'b01,
    PWR_DPD     = 2'b10,
    PWR_RETAIN  = 2'b11
  } pwr_e;

  // Mode register: sleep type bit plus two partition bits
  typedef struct packed {
    logic       keep;
    logic [1:0] part;
  } mode_t;

  localparam mode_t MODE_RESET = '{keep: 1'b1, part: 2'b00};

  function automatic cmd_e decode_pins(input logic ce_n, input logic zz_n,
                                       input logic oe_n, input logic we_n);
    cmd_e c;
    if (ce_n)       c = zz_n ? CMD_DESEL : CMD_SLEEP;
    else if (!zz_n) c = we_n ? CMD_NOP : CMD_CFG;
    else if (!we_n) c = CMD_WRITE;
    else if (!oe_n) c = CMD_READ;
    else            c = CMD_NOP;
    return c;
  endfunction

  // Number of words kept from address 0 upward for a partition code
  function automatic int unsigned keep_words(input logic [1:0] part,
                                             input int unsigned depth);
    int unsigned n;
    case (part)
      2'b00:   n = depth;
      2'b01:   n = (depth / 4) * 3;
      2'b10:   n = depth / 2;
      default: n = depth / 4;
    endcase
    return n;
  endfunction

  function automatic logic [LANE_W-1:0] poison_lane(input int unsigned lane);
    return POISON[lane*LANE_W +: LANE_W];
  endfunction

endpackage

// File: rtl/psram_decode.sv
module psram_decode
  import psram_pkg::*;
(
  input  logic ce_n,
  input  logic zz_n,
  input  logic oe_n,
  input  logic we_n,
  output cmd_e cmd,
  output logic rd_en,
  output logic wr_en
);

  always_comb begin
    cmd   = decode_pins(ce_n, zz_n, oe_n, we_n);
    rd_en = (cmd == CMD_READ);
    wr_en = (cmd == CMD_WRITE);
  end

endmodule

// File: rtl/psram_power.sv
module psram_power
  import psram_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned LIM_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic             mode_keep_in,
  input  logic [1:0]       mode_part_in,
  output logic [1:0]       pwr_state,
  output mode_t            mode_q,
  output logic             sleep_enter,
  output logic [LIM_W-1:0] wipe_lim
);

  pwr_e state_q, state_d;
  logic in_sleep;

  assign in_sleep    = (state_q == PWR_DPD) || (state_q == PWR_RETAIN);
  assign sleep_enter = (cmd == CMD_SLEEP) && !in_sleep;
  // Words at or above this limit are lost on entry
  assign wipe_lim    = mode_q.keep ? LIM_W'(keep_words(mode_q.part, DEPTH)) : '0;

  always_comb begin
    state_d = state_q;
    case (cmd)
      CMD_DESEL: state_d = PWR_STANDBY;
      CMD_SLEEP: if (!in_sleep) state_d = mode_q.keep ? PWR_RETAIN : PWR_DPD;
      default:   state_d = PWR_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PWR_STANDBY;
      mode_q  <= MODE_RESET;
    end else begin
      state_q <= state_d;
      if (cmd == CMD_CFG) mode_q <= '{keep: mode_keep_in, part: mode_part_in};
    end
  end

  assign pwr_state = state_q;

endmodule

// File: rtl/psram_array.sv
module psram_array
  import psram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  localparam int unsigned LIM_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] din,
  input  logic              wipe_en,
  input  logic [LIM_W-1:0]  wipe_lim,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  dout_oe
);

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  vld;
    logic [LANE_W-1:0] out_q;
    logic              oe_q;
    logic              lane_wr;
    logic              lane_rd;

    assign lane_wr = wr_en && lane_en[L];
    assign lane_rd = rd_en && lane_en[L];

    always_ff @(posedge clk) begin
      if (lane_wr) mem[addr] <= din[L*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld <= '0;
      end else begin
        if (wipe_en) begin
          for (int i = 0; i < int'(DEPTH); i++) begin
            if (i >= int'(wipe_lim)) vld[i] <= 1'b0;
          end
        end
        if (lane_wr) vld[addr] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_q <= '0;
        oe_q  <= 1'b0;
      end else if (lane_rd) begin
        out_q <= vld[addr] ? mem[addr] : poison_lane(L);
        oe_q  <= 1'b1;
      end else begin
        out_q <= '0;
        oe_q  <= 1'b0;
      end
    end

    assign dout[L*LANE_W +: LANE_W] = out_q;
    assign dout_oe[L]               = oe_q;
  end

endmodule

// File: rtl/psram_model.sv
module psram_model
  import psram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              zz_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [1:0]        dq_oe,
  output logic [1:0]        pwr_state
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned LIM_W = ADDR_W + 1;

  cmd_e             cmd;
  logic             rd_en;
  logic             wr_en;
  logic             sleep_enter;
  mode_t            mode_q;
  logic [LIM_W-1:0] wipe_lim;
  logic [LANES-1:0] lane_en;

  assign lane_en = {~ub_n, ~lb_n};

  psram_decode u_dec (
    .ce_n  (ce_n),
    .zz_n  (zz_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .cmd   (cmd),
    .rd_en (rd_en),
    .wr_en (wr_en)
  );

  psram_power #(.DEPTH(DEPTH)) u_pwr (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .mode_keep_in (addr[4]),
    .mode_part_in (addr[1:0]),
    .pwr_state    (pwr_state),
    .mode_q       (mode_q),
    .sleep_enter  (sleep_enter),
    .wipe_lim     (wipe_lim)
  );

  psram_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .lane_en  (lane_en),
    .din      (dq_in),
    .wipe_en  (sleep_enter),
    .wipe_lim (wipe_lim),
    .dout     (dq_out),
    .dout_oe  (dq_oe)
  );

endmodule

// File: rtl/psram_checker.sv
module psram_checker
  import psram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              zz_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              lb_n,
  input logic              ub_n,
  input logic [1:0]        dq_oe,
  input logic [1:0]        pwr_state,
  input logic              sleep_enter,
  input mode_t             mode_q
);

  logic pin_read;
  logic pin_cfg;
  logic asleep;
  assign pin_read = !ce_n && zz_n && we_n && !oe_n;
  assign pin_cfg  = !ce_n && !zz_n && !we_n;
  assign asleep   = (pwr_state == PWR_DPD) || (pwr_state == PWR_RETAIN);

  AST_RESET_STANDBY: assert property (@(posedge clk) !rst_n |=> (pwr_state == PWR_STANDBY && dq_oe == 2'b00)); // R1
  AST_DESEL_STANDBY: assert property (@(posedge clk) disable iff (!rst_n) (ce_n && zz_n) |=> (pwr_state == PWR_STANDBY)); // R2
  AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n) pin_read |=> (dq_oe == {~$past(ub_n), ~$past(lb_n)})); // R4
  AST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !pin_read |=> (dq_oe == 2'b00)); // R5
  AST_ENABLED_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) !ce_n |=> (pwr_state == PWR_ACTIVE)); // R5
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) pin_cfg |=> (mode_q == {$past(addr[4]), $past(addr[1:0])})); // R6
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !pin_cfg |=> $stable(mode_q)); // R6
  AST_SLEEP_KIND: assert property (@(posedge clk) disable iff (!rst_n) sleep_enter |=> (pwr_state == ($past(mode_q.keep) ? PWR_RETAIN : PWR_DPD))); // R7
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (asleep && ce_n && !zz_n) |=> $stable(pwr_state)); // R7

endmodule

bind psram_model psram_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr        (addr),
  .ce_n        (ce_n),
  .zz_n        (zz_n),
  .oe_n        (oe_n),
  .we_n        (we_n),
  .lb_n        (lb_n),
  .ub_n        (ub_n),
  .dq_oe       (dq_oe),
  .pwr_state   (pwr_state),
  .sleep_enter (sleep_enter),
  .mode_q      (mode_q)
);

// File: tb/psram_model_test.sv
`timescale 1ns/1ps
module psram_model_test;

  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b1, zz_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic          lb_n = 1'b1, ub_n = 1'b1;
  logic [15:0]   dq_in = '0;
  logic [15:0]   dq_out;
  logic [1:0]    dq_oe;
  logic [1:0]    pwr_state;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference state
  int m_lo [DEPTH];
  int m_hi [DEPTH];
  bit v_lo [DEPTH];
  bit v_hi [DEPTH];
  int st = 1;          // 0 active 1 standby 2 dpd 3 retain
  bit m_keep = 1;
  int m_part = 0;

  always #10 clk = ~clk;

  psram_model #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .zz_n(zz_n),
    .oe_n(oe_n), .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .pwr_state(pwr_state)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int kept(input int part);
    if (part == 0) return DEPTH;
    if (part == 1) return DEPTH - DEPTH / 4;
    if (part == 2) return DEPTH / 2;
    return DEPTH / 4;
  endfunction

  // One clock: drive pins, advance the model, compare after the edge
  task automatic step(input string req, input bit c, input bit z, input bit o,
                      input bit w, input bit lb, input bit ub,
                      input int a, input int d);
    int e_out = 0;
    int e_oe  = 0;
    @(negedge clk);
    ce_n = c; zz_n = z; oe_n = o; we_n = w; lb_n = lb; ub_n = ub;
    addr = AW'(a); dq_in = 16'(d);
    if (c && z) st = 1;
    else if (c && !z) begin
      if (st < 2) begin
        if (m_keep) begin
          st = 3;
          for (int i = kept(m_part); i < DEPTH; i++) begin v_lo[i] = 0; v_hi[i] = 0; end
        end else begin
          st = 2;
          for (int i = 0; i < DEPTH; i++) begin v_lo[i] = 0; v_hi[i] = 0; end
        end
      end
    end else begin
      st = 0;
      if (!z && !w) begin m_keep = a[4]; m_part = a & 3; end
      else if (z && !w) begin
        if (!lb) begin m_lo[a] = d & 255; v_lo[a] = 1; end
        if (!ub) begin m_hi[a] = (d >> 8) & 255; v_hi[a] = 1; end
      end else if (z && !o) begin
        if (!lb) begin e_oe += 1; e_out += v_lo[a] ? m_lo[a] : 'hAD; end
        if (!ub) begin e_oe += 2; e_out += (v_hi[a] ? m_hi[a] : 'hDE) << 8; end
      end
    end
    @(posedge clk); #2;
    check(req, "dq_out", int'(dq_out), e_out);
    check(req, "dq_oe", int'(dq_oe), e_oe);
    check(req, "pwr_state", int'(pwr_state), st);
  endtask

  task automatic wr(input string req, input int a, input int d);
    step(req, 0, 1, 1, 0, 0, 0, a, d);
  endtask
  task automatic rd(input string req, input int a);
    step(req, 0, 1, 0, 1, 0, 0, a, 0);
  endtask
  task automatic cfg(input string req, input int v);
    step(req, 0, 0, 1, 0, 1, 1, v, 0);
  endtask
  task automatic nap(input string req, input int n);
    for (int k = 0; k < n; k++) step(req, 1, 0, 1, 1, 1, 1, 0, 0);
    step(req, 1, 1, 1, 1, 1, 1, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", "reset pwr_state", int'(pwr_state), 1);
    check("R1", "reset dq_oe", int'(dq_oe), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1", "post-reset pwr_state", int'(pwr_state), 1);

    rd("R1", 5);                                   // unwritten word: poison
    for (int i = 0; i < 8; i++) wr("R3", i, 16'h1100 + i * 16'h0111);
    step("R3", 0, 1, 0, 0, 0, 0, 64, 16'h6464);    // write with oe_n low
    wr("R3", 130, 16'hA0B0);
    wr("R3", 200, 16'hC8C8);
    wr("R3", 250, 16'hFAFA);
    step("R3", 0, 1, 1, 0, 0, 1, 3, 16'hFF77);     // low lane only
    step("R3", 0, 1, 1, 0, 1, 0, 4, 16'h88FF);     // high lane only
    for (int i = 0; i < 4; i++) rd("R10", i);      // page sweep
    for (int i = 4; i < 8; i++) rd("R10", i);
    step("R4", 0, 1, 0, 1, 0, 1, 6, 0);            // low lane read
    step("R4", 0, 1, 0, 1, 1, 0, 6, 0);            // high lane read
    step("R4", 0, 1, 0, 1, 1, 1, 6, 0);            // no lanes
    step("R5", 0, 1, 1, 1, 0, 0, 6, 0);            // enabled, idle
    step("R2", 1, 1, 0, 0, 0, 0, 7, 16'h0BAD);     // deselected write attempt
    rd("R2", 7);
    cfg("R6", 5'h12);                              // retain, half
    step("R6", 0, 0, 0, 1, 0, 0, 5'h03, 0);        // register access without we
    rd("R6", 200);
    nap("R7", 3);
    rd("R9", 64);
    rd("R9", 130);
    rd("R9", 200);
    step("R11", 0, 1, 1, 0, 0, 1, 130, 16'h0055);  // low lane only after loss
    rd("R11", 130);
    cfg("R7", 5'h03);                              // power-down type
    nap("R7", 2);
    rd("R8", 0);
    rd("R8", 64);
    wr("R3", 130, 16'h1234);
    wr("R3", 200, 16'h5678);
    cfg("R9", 5'h11);                              // retain three quarters
    nap("R9", 1);
    rd("R9", 130);
    rd("R9", 200);
    wr("R3", 10, 16'h0A0A);
    wr("R3", 100, 16'h6464);
    cfg("R9", 5'h13);                              // retain one quarter
    nap("R9", 1);
    rd("R9", 10);
    rd("R9", 100);
    wr("R3", 250, 16'h7E7E);
    cfg("R9", 5'h10);                              // retain all
    nap("R9", 1);
    rd("R9", 250);

    for (int n = 0; n < 3000; n++) begin
      int a = $urandom % DEPTH;
      int d = $urandom % 65536;
      bit c = ($urandom % 10) == 0;
      bit z = ($urandom % 12) != 0;
      bit o = ($urandom % 3) == 0;
      bit w = ($urandom % 3) != 0;
      step("R4", c, z, o, w, ($urandom % 4) == 0, ($urandom % 4) == 0, a, d);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule